// File: doc/BRIEF.md
# DMA Channel Request and Enable Control

This block is the control side of one DMA channel. A request comes from one of two places. Software can trigger one by writing a one-shot bit. A rising edge on one peripheral interrupt-request flag also raises one, and a five-bit source selector picks which flag. Every request sets a pending flag, whether or not the channel is enabled. While the channel is enabled and a request is pending, the block offers a single transfer to a datapath over a valid/ready handshake. The pending flag clears at the moment that handshake completes.

Software writes a one to the enable bit to enable the channel. Every such write reloads the transfer counter from its reload register and reloads the working pointer, even when the channel is already enabled. The pointer takes the source address when the source direction is marked forward, and otherwise the destination address when that direction is marked forward. Each completed transfer advances the pointer by one and decrements the counter. When the counter reaches zero, the channel disables itself and pulses `done` for one cycle. Software cannot set the pending flag directly. It can only clear it, and a request that arrives in the same cycle as a clear wins. This lets software clear a false request after changing the selector. It also allows a safe enable: the write sets the enable bit and writes a one to the pending bit together, so a request arriving at that moment is not lost.

Back-pressure: `xfer_valid` stays high until `xfer_ready` is seen. A transfer counts only on a cycle where both are high. The datapath may hold `xfer_ready` low for any length of time. Only a software write can withdraw the offer: disabling the channel or clearing the pending flag.

Top module: `dma_chan_ctrl`

## Requirements
- R1: The peripheral source index is {bank, sel}. Here sel is SEL write bits [3:0] and bank is SEL bit 4, the index MSB. Only a rising edge on `irq_flags[index]` makes a request; edges on other flags are ignored.
- R2: Any request sets `req_pending` at the next clock edge, whether the channel is enabled or disabled.
- R3: `xfer_valid` is high exactly when the channel is enabled and a request is pending. It holds while `xfer_ready` is low. A completed handshake clears `req_pending`.
- R4: A CTRL write (address 0) with bit 1 = 1 leaves `req_pending` unchanged. With bit 1 = 0, it clears `req_pending`.
- R5: A CTRL write with bit 0 = 1 enables the channel. It loads `xfer_count` from RELOAD (address 4), even when the channel is already enabled.
- R6: On that write, the pointer loads from SRC (address 2) when CTRL bit 2 is 1. Otherwise it loads from DST (address 3) when bit 3 is 1. Otherwise the pointer is unchanged.
- R7: Each completed transfer decrements `xfer_count` and increments `xfer_ptr` by one.
- R8: A transfer that takes `xfer_count` from 1 to 0 clears `chan_en` and raises `done` for exactly one cycle.
- R9: A request in the same cycle as a software clear of the pending flag wins, and `req_pending` stays 1.
- R10: A SEL write (address 1) with bit 5 = 1 makes one software request.
- R11: A CTRL write with bits 0 and 1 both set enables the channel and keeps a pending request.
- R12: After reset, `req_pending`, `chan_en`, `xfer_valid`, `done`, `xfer_count` and `xfer_ptr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 CTRL, 1 SEL, 2 SRC, 3 DST, 4 RELOAD |
| wr_data | input | ADDR_W | Register write data |
| irq_flags | input | 2**(SEL_W+1) | Peripheral interrupt-request flags |
| xfer_valid | output | 1 | Transfer offered to the datapath |
| xfer_ready | input | 1 | Datapath accepts the transfer |
| xfer_ptr | output | ADDR_W | Working address pointer |
| xfer_count | output | CNT_W | Remaining transfer count |
| chan_en | output | 1 | Channel enable state |
| req_pending | output | 1 | Pending-request flag |
| done | output | 1 | One-cycle terminal-count pulse |

## Verification
A wrong pending flag shows up on `xfer_valid` in the very next cycle whenever the channel is enabled. While the channel is disabled it is still visible on `req_pending`, so each request or clear case can be observed one edge after it happens. A wrong reload source or count shows on `xfer_ptr` and `xfer_count` one edge after the enabling write. A miscount shows up as `done` arriving a transfer early or late. The stimulus therefore samples every output one cycle after each write, edge and handshake.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_SEL    = 3'd1,
    REG_SRC    = 3'd2,
    REG_DST    = 3'd3,
    REG_RELOAD = 3'd4
  } reg_addr_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_PEND = 1;
  localparam int CTRL_SRCF = 2;
  localparam int CTRL_DSTF = 3;
endpackage

// File: rtl/dma_req_sel.sv
module dma_req_sel #(
  parameter int SEL_W = 4,
  localparam int NSRC = 2 ** (SEL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [SEL_W:0]   sel_din,
  input  logic             trig_in,
  input  logic [NSRC-1:0]  irq_flags,
  output logic             req
);
  logic [SEL_W:0] sel_q;
  logic           prev_q;
  logic           cur_flag;

  assign cur_flag = irq_flags[sel_q];
  // one rising edge of the chosen flag, or a software trigger, is one request
  assign req = (cur_flag & ~prev_q) | (sel_wr & trig_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= cur_flag;
      if (sel_wr) sel_q <= sel_din;
    end
  end
endmodule

// File: rtl/dma_pend_flag.sv
module dma_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic fire,
  input  logic clr_wr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend <= 1'b0;
    else if (req)           pend <= 1'b1;  // a request beats any clear
    else if (fire || clr_wr) pend <= 1'b0;
  end
endmodule

// File: rtl/dma_ptr_cnt.sv
module dma_ptr_cnt
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              fire,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic              done
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  reload_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_SRC:    src_q    <= wr_data;
        REG_DST:    dst_q    <= wr_data;
        REG_RELOAD: reload_q <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      cnt  <= '0;
      en   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctrl_wr) begin
        en <= wr_data[CTRL_EN];
        if (wr_data[CTRL_EN]) begin
          cnt <= reload_q;
          if (wr_data[CTRL_SRCF])      ptr <= src_q;
          else if (wr_data[CTRL_DSTF]) ptr <= dst_q;
        end
      end else if (fire) begin
        cnt <= cnt - CNT_W'(1);
        ptr <= ptr + ADDR_W'(1);
        if (cnt == CNT_W'(1)) begin
          en   <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  localparam int NSRC  = 2 ** (SEL_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [NSRC-1:0]   irq_flags,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_ptr,
  output logic [CNT_W-1:0]  xfer_count,
  output logic              chan_en,
  output logic              req_pending,
  output logic              done
);
  logic req, fire, ctrl_wr, sel_wr;

  assign ctrl_wr    = wr_en && (wr_addr == REG_CTRL);
  assign sel_wr     = wr_en && (wr_addr == REG_SEL);
  assign xfer_valid = chan_en & req_pending;
  assign fire       = xfer_valid & xfer_ready;

  dma_req_sel #(.SEL_W(SEL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr),
    .sel_din(wr_data[SEL_W:0]), .trig_in(wr_data[SEL_W+1]),
    .irq_flags(irq_flags), .req(req)
  );

  dma_pend_flag u_pend (
    .clk(clk), .rst_n(rst_n), .req(req), .fire(fire),
    .clr_wr(ctrl_wr & ~wr_data[CTRL_PEND]), .pend(req_pending)
  );

  dma_ptr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fire(fire), .ptr(xfer_ptr), .cnt(xfer_count),
    .en(chan_en), .done(done)
  );
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             fire,
  input logic             ctrl_wr,
  input logic             wr_en,
  input logic             wd_en,
  input logic             wd_pend,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic             req_pending,
  input logic             chan_en,
  input logic             done,
  input logic [CNT_W-1:0] xfer_count
);
  p_req_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> req_pending);
  p_fire_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req |=> !req_pending);
  p_hold_under_bp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready && !wr_en |=> xfer_valid);
  p_one_no_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wd_pend && !req && !fire |=> $stable(req_pending));
  p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && wd_en |=> chan_en && !done);
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ctrl_wr |=> xfer_count == $past(xfer_count) - CNT_W'(1));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chan_en && xfer_count == '0);
  p_req_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req && ctrl_wr && !wd_pend |=> req_pending);
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .fire(fire), .ctrl_wr(ctrl_wr),
  .wr_en(wr_en), .wd_en(wr_data[0]), .wd_pend(wr_data[1]),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .req_pending(req_pending), .chan_en(chan_en), .done(done),
  .xfer_count(xfer_count)
);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 16;
  localparam int NSRC   = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [ADDR_W-1:0] wr_data = '0;
  logic [NSRC-1:0]   irq = '0;
  logic              ready = 1'b0;
  logic              valid, chan_en, pend, done;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_chan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_flags(irq), .xfer_valid(valid),
    .xfer_ready(ready), .xfer_ptr(ptr), .xfer_count(cnt),
    .chan_en(chan_en), .req_pending(pend), .done(done)
  );

  typedef struct packed {
    logic              wen;
    logic [2:0]        addr;
    logic [ADDR_W-1:0] data;
    logic [NSRC-1:0]   irq;
    logic              rdy;
    logic [3:0]        e_flags;  // {pend, en, valid, done}
    logic [CNT_W-1:0]  e_cnt;
    logic [ADDR_W-1:0] e_ptr;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b1, 3'd2, 20'h00100, 32'h0,   1'b0, 4'b0000, 16'd0, 20'h0},
    '{1'b1, 3'd3, 20'h00200, 32'h0,   1'b0, 4'b0000, 16'd0, 20'h0},
    '{1'b1, 3'd4, 20'h00003, 32'h0,   1'b0, 4'b0000, 16'd0, 20'h0},
    '{1'b1, 3'd1, 20'h00005, 32'h0,   1'b0, 4'b0000, 16'd0, 20'h0},
    '{1'b0, 3'd0, 20'h00000, 32'h20,  1'b0, 4'b1000, 16'd0, 20'h0},
    '{1'b1, 3'd0, 20'h00007, 32'h20,  1'b0, 4'b1110, 16'd3, 20'h100},
    '{1'b0, 3'd0, 20'h00000, 32'h20,  1'b1, 4'b0100, 16'd2, 20'h101},
    '{1'b0, 3'd0, 20'h00000, 32'h0,   1'b1, 4'b0100, 16'd2, 20'h101},
    '{1'b0, 3'd0, 20'h00000, 32'h20,  1'b1, 4'b1110, 16'd2, 20'h101},
    '{1'b0, 3'd0, 20'h00000, 32'h20,  1'b1, 4'b0100, 16'd1, 20'h102},
    '{1'b1, 3'd1, 20'h00020, 32'h20,  1'b0, 4'b1110, 16'd1, 20'h102},
    '{1'b0, 3'd0, 20'h00000, 32'h20,  1'b1, 4'b0001, 16'd0, 20'h103},
    '{1'b0, 3'd0, 20'h00000, 32'h20,  1'b1, 4'b0000, 16'd0, 20'h103}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(logic we, logic [2:0] a, logic [ADDR_W-1:0] d,
                      logic [NSRC-1:0] ir, logic rd);
    wr_en = we; wr_addr = a; wr_data = d; irq = ir; ready = rd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset", {pend, chan_en, valid, done, 12'h0, cnt, ptr}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R5 R7 R8 R10 R11
    for (int i = 0; i < 13; i++) begin
      step(VEC[i].wen, VEC[i].addr, VEC[i].data, VEC[i].irq, VEC[i].rdy);
      check($sformatf("R2 R3 R7 R8 table step %0d", i),
            {pend, chan_en, valid, done, cnt, ptr},
            {VEC[i].e_flags, VEC[i].e_cnt, VEC[i].e_ptr});
    end

    // R1: select bank 1, sel 3 -> index 19
    step(1'b1, 3'd1, 20'h13, 32'h0, 1'b0);
    step(1'b0, 3'd0, 20'h0, 32'h8, 1'b0);
    check("R1 unselected flag ignored", pend, 1'b0);
    step(1'b0, 3'd0, 20'h0, 32'h80008, 1'b0);
    check("R1 selected index 19 edge", pend, 1'b1);

    // R4: writing 1 keeps, writing 0 clears
    step(1'b1, 3'd0, 20'h2, 32'h80008, 1'b0);
    check("R4 write one no effect", pend, 1'b1);
    step(1'b1, 3'd0, 20'h0, 32'h80008, 1'b0);
    check("R4 write zero clears", pend, 1'b0);

    // R9: request and clear in same cycle
    step(1'b0, 3'd0, 20'h0, 32'h0, 1'b0);
    step(1'b1, 3'd0, 20'h0, 32'h80000, 1'b0);
    check("R9 request beats clear", pend, 1'b1);

    // R6: pointer reload source
    step(1'b1, 3'd0, 20'h9, 32'h80000, 1'b0);
    check("R6 dst forward", ptr, 20'h200);
    check("R4 enable write with pend 0 clears", pend, 1'b0);
    step(1'b1, 3'd0, 20'h1, 32'h80000, 1'b0);
    check("R6 neither forward keeps pointer", ptr, 20'h200);
    step(1'b1, 3'd0, 20'hD, 32'h80000, 1'b0);
    check("R6 both forward picks src", ptr, 20'h100);

    // R3 back-pressure, R10 software trigger
    step(1'b1, 3'd1, 20'h33, 32'h80000, 1'b0);
    check("R10 software trigger", valid, 1'b1);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 3'd0, 20'h0, 32'h80000, 1'b0);
      check("R3 valid held under back-pressure", {valid, cnt}, {1'b1, 16'd3});
    end
    step(1'b0, 3'd0, 20'h0, 32'h80000, 1'b1);
    check("R7 handshake step", {pend, valid, cnt, ptr}, {1'b0, 1'b0, 16'd2, 20'h101});

    // R5: re-enable while enabled reloads
    step(1'b1, 3'd0, 20'h5, 32'h80000, 1'b0);
    check("R5 re-enable reloads", {chan_en, cnt, ptr}, {1'b1, 16'd3, 20'h100});

    // R8 with reload of 1
    step(1'b1, 3'd4, 20'h1, 32'h80000, 1'b0);
    step(1'b1, 3'd0, 20'h5, 32'h80000, 1'b0);
    check("R5 reload one", cnt, 16'd1);
    step(1'b1, 3'd1, 20'h33, 32'h80000, 1'b1);
    check("R10 trigger with ready", valid, 1'b1);
    step(1'b0, 3'd0, 20'h0, 32'h80000, 1'b1);
    check("R8 terminal count", {done, chan_en, cnt, ptr}, {1'b1, 1'b0, 16'd0, 20'h101});
    step(1'b0, 3'd0, 20'h0, 32'h80000, 1'b1);
    check("R8 done one cycle", {done, valid}, 2'b00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule